// File: doc/BRIEF.md
# Low-Power Mode Sequencer for an 8-bit Core

This block decides when a small 8-bit microcontroller core runs, sleeps lightly or stops completely. Software sets one of two mode bits through a register write. A light sleep (idle) removes only the CPU clock. The peripherals and the interrupt logic keep running, the bus strobes are held inactive-high and the port outputs freeze. A deep sleep (power-down) also drops the oscillator enable, so every clock stops while RAM and special-function registers keep their contents.

Idle ends when any enabled interrupt becomes active, or when the reset pin has been held high for a full two machine cycles. Power-down ends in one of two ways. The first is a reset. The second is a two-phase handshake on an enabled external interrupt pin. A low level on the pin restarts the oscillator and starts a stabilization count. The exit finishes only when the count has expired and a pin that went low has been released. On an interrupt-driven exit the block pulses a wake indication for one cycle and tells the interrupt logic which source to service.

The controller's own clock `clk` stands for the oscillator period. A stopped oscillator is shown only through `oscEn`. The restart delay is modelled by the counter.

Top module: `pwrModeCtrl`

## Requirements
- R1: After `rstN` is released the block is active. `cpuClkEn`, `periphClkEn` and `oscEn` are 1, and `strobeHold`, `idleBit`, `pdBit` and `wakeValid` are 0.
- R2: A write (`pconWe`=1) with `pconIdle`=1 and `pconPd`=0 in the active state enters idle on the next cycle. In idle, `cpuClkEn`=0, `periphClkEn`=1, `oscEn`=1, `strobeHold`=1 and `idleBit`=1.
- R3: In idle, a low level on `int0N` with `ex0En`=1, a low level on `int1N` with `ex1En`=1, or `otherIrq`=1 ends idle at the next clock edge. `wakeValid` is 1 for exactly that one cycle. A low pin whose enable is 0 is ignored.
- R4: In idle, `rstPin` must be sampled high on RST_HOLD consecutive edges (default 24) before the block returns to active, with no wake pulse. A shorter pulse leaves the block in idle. When the hold completes on the same edge as an interrupt, the reset exit wins.
- R5: A write with `pconPd`=1 in the active state enters power-down on the next cycle, even if `pconIdle` is also 1. In power-down all three clock enables are 0, and `strobeHold`=1 and `pdBit`=1.
- R6: In power-down with the oscillator stopped, `otherIrq` and low pins whose enable is 0 have no effect: `oscEn` stays 0.
- R7: A low level on an enabled external pin in stopped power-down sets `oscEn`=1 on the next cycle while `cpuClkEn` stays 0. A counter then advances once per edge from 0 to STAB_CYCLES (default 16). The block returns to active, with `wakeValid` pulsed, on the first edge at which the count equals STAB_CYCLES and a release has already been registered. A release is a pin that was low since the restart and is now sampled high.
- R8: On a power-down exit, `wakeSrc` selects among the pins that were low during the restart. If both were low, it selects INT1 when `px1`=1 and `px0`=0, and INT0 otherwise.
- R9: `rstPin`=1 during either power-down phase returns the block to active on the next cycle with `oscEn`=1, both mode bits cleared and no wake pulse.
- R10: `wakeSrc` encodes 0 as INT0, 1 as INT1 and 2 as another source. On an idle exit the two pins follow the priority rule of R8, and `otherIrq` is chosen only when neither enabled pin is low. `wakeSrc` holds its value until the next wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rstN | input | 1 | Asynchronous controller reset, active low |
| pconWe | input | 1 | Power-control register write strobe |
| pconIdle | input | 1 | Idle bit of the written value |
| pconPd | input | 1 | Power-down bit of the written value |
| rstPin | input | 1 | Hardware reset pin, active high |
| int0N | input | 1 | External interrupt pin 0, active low |
| int1N | input | 1 | External interrupt pin 1, active low |
| ex0En | input | 1 | Enable for external interrupt 0 |
| ex1En | input | 1 | Enable for external interrupt 1 |
| px0 | input | 1 | Priority bit of external interrupt 0 |
| px1 | input | 1 | Priority bit of external interrupt 1 |
| otherIrq | input | 1 | Any other enabled pending interrupt |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Timer, serial and interrupt-logic clock enable |
| oscEn | output | 1 | Oscillator enable |
| strobeHold | output | 1 | Holds the bus strobes high |
| idleBit | output | 1 | Idle mode bit as read back |
| pdBit | output | 1 | Power-down mode bit as read back |
| wakeValid | output | 1 | One-cycle pulse on an interrupt-driven wake |
| wakeSrc | output | 2 | Source to service: 0 INT0, 1 INT1, 2 other |

## Verification
If the mode state is corrupted, the clock-enable pattern shows it on the very next cycle. Idle, stopped and restarting power-down each drive a different combination of `cpuClkEn`, `periphClkEn` and `oscEn`. Faults in the stabilization counter, the reset-hold counter or the release tracker stay hidden until an exit is attempted. They then move the return of `cpuClkEn` one or more cycles early or late, or give a wrong `wakeSrc`. For that reason the reference model is compared against every output on every cycle rather than only at the end of a sequence.

// File: rtl/pwrPkg.sv
package pwrPkg;

  typedef enum logic [1:0] {
    ST_ACTIVE     = 2'd0,
    ST_IDLE       = 2'd1,
    ST_PD_STOP    = 2'd2,
    ST_PD_RESTART = 2'd3
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic trackLoad;   // entering restart phase
    logic trackRun;    // in restart phase
    logic rstRun;      // in idle, count reset-pin hold
    logic wakeLoad;    // emit wake pulse
    logic wakeFromPd;  // wake source comes from restart tracking
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic stabDone;
    logic rstHeld;
    logic relSeen;
    logic pdPinLow;
    logic idleIrq;
  } dpStatus_t;

  localparam logic [1:0] SRC_INT0  = 2'd0;
  localparam logic [1:0] SRC_INT1  = 2'd1;
  localparam logic [1:0] SRC_OTHER = 2'd2;

  function automatic logic [1:0] pickPin(input logic [1:0] lowMask,
                                         input logic p0, input logic p1);
    if (lowMask == 2'b11) return (p1 && !p0) ? SRC_INT1 : SRC_INT0;
    else if (lowMask[0]) return SRC_INT0;
    else return SRC_INT1;
  endfunction

endpackage

// File: rtl/pwrDatapath.sv
module pwrDatapath
  import pwrPkg::*;
#(
  parameter int STAB_CYCLES = 16,
  parameter int RST_HOLD    = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        rstPin,
  input  logic        int0N,
  input  logic        int1N,
  input  logic        ex0En,
  input  logic        ex1En,
  input  logic        px0,
  input  logic        px1,
  input  logic        otherIrq,
  output dpStatus_t   status,
  output logic        wakeValid,
  output logic [1:0]  wakeSrc
);
  localparam int CNT_W = $clog2(STAB_CYCLES + 1);
  localparam int RST_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES);
  localparam logic [RST_W-1:0] RST_LAST = RST_W'(RST_HOLD - 1);

  logic [CNT_W-1:0] stabCnt;
  logic [RST_W-1:0] rstCnt;
  logic [1:0]       lowMask;
  logic             relSeen;
  logic [1:0]       pinLow;
  logic [1:0]       idleSrc;

  assign pinLow = {ex1En && !int1N, ex0En && !int0N};

  always_comb begin
    if (pinLow != 2'b00) idleSrc = pickPin(pinLow, px0, px1);
    else                 idleSrc = SRC_OTHER;
  end

  assign status.stabDone = (stabCnt == CNT_LAST);
  assign status.rstHeld  = rstPin && (rstCnt == RST_LAST);
  assign status.relSeen  = relSeen;
  assign status.pdPinLow = |pinLow;
  assign status.idleIrq  = (|pinLow) || otherIrq;

  // restart-phase tracking: stabilization count, low pins, release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stabCnt <= '0;
      lowMask <= '0;
      relSeen <= 1'b0;
    end else if (strobe.trackLoad) begin
      stabCnt <= '0;
      lowMask <= pinLow;
      relSeen <= 1'b0;
    end else if (strobe.trackRun) begin
      if (stabCnt != CNT_LAST) stabCnt <= stabCnt + 1'b1;
      relSeen <= relSeen || ((lowMask & {int1N, int0N}) != 2'b00);
      lowMask <= lowMask | pinLow;
    end
  end

  // reset-pin hold counter while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    rstCnt <= '0;
    else if (strobe.rstRun && rstPin && !status.rstHeld) rstCnt <= rstCnt + 1'b1;
    else                                          rstCnt <= '0;
  end

  // wake indication
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeValid <= 1'b0;
      wakeSrc   <= SRC_INT0;
    end else begin
      wakeValid <= strobe.wakeLoad;
      if (strobe.wakeLoad)
        wakeSrc <= strobe.wakeFromPd ? pickPin(lowMask, px0, px1) : idleSrc;
    end
  end
endmodule

// File: rtl/pwrControl.sv
module pwrControl
  import pwrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  input  logic        pconWe,
  input  logic        pconIdle,
  input  logic        pconPd,
  input  logic        rstPin,
  output ctrlStrobe_t strobe,
  output logic        cpuClkEn,
  output logic        periphClkEn,
  output logic        oscEn,
  output logic        strobeHold,
  output logic        idleBit,
  output logic        pdBit
);
  pwrState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_ACTIVE: begin
        if (pconWe && pconPd)        nextState = ST_PD_STOP;
        else if (pconWe && pconIdle) nextState = ST_IDLE;
      end
      ST_IDLE: begin
        strobe.rstRun = 1'b1;
        if (status.rstHeld) nextState = ST_ACTIVE;
        else if (status.idleIrq) begin
          nextState       = ST_ACTIVE;
          strobe.wakeLoad = 1'b1;
        end
      end
      ST_PD_STOP: begin
        if (rstPin) nextState = ST_ACTIVE;
        else if (status.pdPinLow) begin
          nextState        = ST_PD_RESTART;
          strobe.trackLoad = 1'b1;
        end
      end
      ST_PD_RESTART: begin
        strobe.trackRun = 1'b1;
        if (rstPin) nextState = ST_ACTIVE;
        else if (status.stabDone && status.relSeen) begin
          nextState         = ST_ACTIVE;
          strobe.wakeLoad   = 1'b1;
          strobe.wakeFromPd = 1'b1;
        end
      end
      default: nextState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= nextState;
  end

  assign cpuClkEn    = (state == ST_ACTIVE);
  assign periphClkEn = (state == ST_ACTIVE) || (state == ST_IDLE);
  assign oscEn       = (state != ST_PD_STOP);
  assign strobeHold  = (state != ST_ACTIVE);
  assign idleBit     = (state == ST_IDLE);
  assign pdBit       = (state == ST_PD_STOP) || (state == ST_PD_RESTART);
endmodule

// File: rtl/pwrModeCtrl.sv
module pwrModeCtrl
  import pwrPkg::*;
#(
  parameter int STAB_CYCLES = 16,
  parameter int RST_HOLD    = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pconWe,
  input  logic       pconIdle,
  input  logic       pconPd,
  input  logic       rstPin,
  input  logic       int0N,
  input  logic       int1N,
  input  logic       ex0En,
  input  logic       ex1En,
  input  logic       px0,
  input  logic       px1,
  input  logic       otherIrq,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       oscEn,
  output logic       strobeHold,
  output logic       idleBit,
  output logic       pdBit,
  output logic       wakeValid,
  output logic [1:0] wakeSrc
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  pwrControl u_ctrl (
    .clk(clk), .rstN(rstN), .status(status),
    .pconWe(pconWe), .pconIdle(pconIdle), .pconPd(pconPd), .rstPin(rstPin),
    .strobe(strobe), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .oscEn(oscEn), .strobeHold(strobeHold), .idleBit(idleBit), .pdBit(pdBit)
  );

  pwrDatapath #(.STAB_CYCLES(STAB_CYCLES), .RST_HOLD(RST_HOLD)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rstPin(rstPin),
    .int0N(int0N), .int1N(int1N), .ex0En(ex0En), .ex1En(ex1En),
    .px0(px0), .px1(px1), .otherIrq(otherIrq),
    .status(status), .wakeValid(wakeValid), .wakeSrc(wakeSrc)
  );
endmodule

// File: rtl/pwrModeCtrlChk.sv
module pwrModeCtrlChk (
  input logic       clk,
  input logic       rstN,
  input logic       pconWe,
  input logic       pconIdle,
  input logic       pconPd,
  input logic       rstPin,
  input logic       int0N,
  input logic       int1N,
  input logic       ex0En,
  input logic       ex1En,
  input logic       otherIrq,
  input logic       cpuClkEn,
  input logic       periphClkEn,
  input logic       oscEn,
  input logic       idleBit,
  input logic       pdBit,
  input logic       strobeHold,
  input logic       wakeValid
);
  AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    idleBit |-> (!cpuClkEn && periphClkEn && oscEn && strobeHold)); // R2
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wakeValid |=> !wakeValid); // R3
  AST_WAKE_RUNS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    wakeValid |-> cpuClkEn); // R3
  AST_PD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && pconWe && pconPd) |=> (pdBit && !oscEn && !idleBit)); // R5
  AST_PD_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (pdBit && !oscEn && !rstPin && !(ex0En && !int0N) && !(ex1En && !int1N))
      |=> !oscEn); // R6
  AST_PD_NO_CPU: assert property (@(posedge clk) disable iff (!rstN)
    pdBit |-> (!cpuClkEn && !periphClkEn)); // R7
  AST_PD_RESET_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (pdBit && rstPin) |=> (cpuClkEn && oscEn && !pdBit && !wakeValid)); // R9
endmodule

bind pwrModeCtrl pwrModeCtrlChk u_chk (
  .clk(clk), .rstN(rstN), .pconWe(pconWe), .pconIdle(pconIdle), .pconPd(pconPd),
  .rstPin(rstPin), .int0N(int0N), .int1N(int1N), .ex0En(ex0En), .ex1En(ex1En),
  .otherIrq(otherIrq), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
  .oscEn(oscEn), .idleBit(idleBit), .pdBit(pdBit), .strobeHold(strobeHold),
  .wakeValid(wakeValid)
);

// File: tb/pwrModeCtrl_bench.sv
`timescale 1ns/1ps
module pwrModeCtrl_bench;
  localparam int STAB = 16;
  localparam int HOLD = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pconWe = 0, pconIdle = 0, pconPd = 0, rstPin = 0;
  logic int0N = 1, int1N = 1, ex0En = 0, ex1En = 0, px0 = 0, px1 = 0, otherIrq = 0;
  logic cpuClkEn, periphClkEn, oscEn, strobeHold, idleBit, pdBit, wakeValid;
  logic [1:0] wakeSrc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pwrModeCtrl #(.STAB_CYCLES(STAB), .RST_HOLD(HOLD)) u_pwrModeCtrl (
    .clk(clk), .rstN(rstN), .pconWe(pconWe), .pconIdle(pconIdle), .pconPd(pconPd),
    .rstPin(rstPin), .int0N(int0N), .int1N(int1N), .ex0En(ex0En), .ex1En(ex1En),
    .px0(px0), .px1(px1), .otherIrq(otherIrq), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .oscEn(oscEn), .strobeHold(strobeHold),
    .idleBit(idleBit), .pdBit(pdBit), .wakeValid(wakeValid), .wakeSrc(wakeSrc)
  );

  // behavioural reference: 0 active, 1 idle, 2 pd stopped, 3 pd restarting
  int mState = 0, mCnt = 0, mRst = 0, mLow = 0, mRel = 0, mWake = 0, mSrc = 0;

  function automatic int prio(int m);
    if (m == 3) return (px1 && !px0) ? 1 : 0;
    return (m == 1) ? 0 : 1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mRst = 0; mLow = 0; mRel = 0; mWake = 0; mSrc = 0;
    end else begin
      int pins;
      pins = ((ex1En && !int1N) ? 2 : 0) + ((ex0En && !int0N) ? 1 : 0);
      mWake = 0;
      case (mState)
        0: begin
          mRst = 0;
          if (pconWe && pconPd) mState = 2;
          else if (pconWe && pconIdle) mState = 1;
        end
        1: begin
          if (rstPin && mRst == HOLD - 1) begin mState = 0; mRst = 0; end
          else begin
            mRst = rstPin ? mRst + 1 : 0;
            if (pins != 0 || otherIrq) begin
              mState = 0; mWake = 1;
              mSrc = (pins != 0) ? prio(pins) : 2;
            end
          end
        end
        2: begin
          if (rstPin) mState = 0;
          else if (pins != 0) begin mState = 3; mCnt = 0; mLow = pins; mRel = 0; end
        end
        default: begin
          if (rstPin) mState = 0;
          else if (mCnt == STAB && mRel != 0) begin
            mState = 0; mWake = 1; mSrc = prio(mLow);
          end else begin
            if (mCnt < STAB) mCnt = mCnt + 1;
            if (((mLow & 1) != 0 && int0N) || ((mLow & 2) != 0 && int1N)) mRel = 1;
            mLow = mLow | pins;
          end
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      string tag;
      int expVec, actVec;
      case (mState)
        0: tag = "R1"; 1: tag = "R2"; 2: tag = "R5"; default: tag = "R7";
      endcase
      expVec = {(mState == 0), (mState < 2), (mState != 2), (mState != 0),
                (mState == 1), (mState >= 2)};
      actVec = {cpuClkEn, periphClkEn, oscEn, strobeHold, idleBit, pdBit};
      check(expVec == actVec, tag, actVec, expVec);
      check(wakeValid == mWake, "R3", wakeValid, mWake);
      check(wakeSrc == mSrc, "R10", wakeSrc, mSrc);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writePcon(input bit idl, input bit pd);
    pconWe = 1; pconIdle = idl; pconPd = pd;
    cyc(1);
    pconWe = 0; pconIdle = 0; pconPd = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1;
    cyc(1);
    check(cpuClkEn && periphClkEn && oscEn && !strobeHold, "R1", cpuClkEn, 1);

    // R2 idle entry, R3 disabled pin ignored, other source wakes (R10)
    writePcon(1, 0);
    cyc(1);
    check(idleBit && !cpuClkEn && periphClkEn, "R2", cpuClkEn, 0);
    int1N = 0; cyc(4);
    check(idleBit == 1, "R3", idleBit, 1);
    int1N = 1; otherIrq = 1; cyc(1); otherIrq = 0;
    check(wakeValid && wakeSrc == 2, "R10", wakeSrc, 2);
    cyc(2);

    // R10 both pins low, INT1 higher priority
    ex0En = 1; ex1En = 1; px1 = 1;
    writePcon(1, 0); cyc(2);
    int0N = 0; int1N = 0; cyc(1); int0N = 1; int1N = 1;
    check(wakeValid && wakeSrc == 1, "R10", wakeSrc, 1);
    cyc(2);

    // R4 short reset pulse ignored, full hold exits
    writePcon(1, 0); cyc(1);
    rstPin = 1; cyc(HOLD - 2); rstPin = 0; cyc(2);
    check(idleBit == 1, "R4", idleBit, 1);
    rstPin = 1; cyc(HOLD - 1);
    check(idleBit == 1, "R4", idleBit, 1);
    cyc(1); rstPin = 0;
    check(cpuClkEn && !wakeValid, "R4", cpuClkEn, 1);
    cyc(2);

    // R5 power-down wins over idle in the same write
    writePcon(1, 1);
    check(pdBit && !idleBit && !oscEn, "R5", oscEn, 0);

    // R6 other sources and disabled pins ignored
    ex1En = 0; otherIrq = 1; int1N = 0; cyc(5);
    check(oscEn == 0, "R6", oscEn, 0);
    otherIrq = 0; int1N = 1; ex1En = 1; cyc(1);

    // R7 enabled pin low restarts oscillator, exit waits for release
    int0N = 0; cyc(1);
    check(oscEn && !cpuClkEn, "R7", oscEn, 1);
    cyc(STAB + 8);
    check(cpuClkEn == 0, "R7", cpuClkEn, 0);
    int0N = 1; cyc(3);
    check(cpuClkEn && wakeSrc == 0, "R7", wakeSrc, 0);
    cyc(2);

    // R7 early release still waits for the stabilization count
    writePcon(0, 1); cyc(1);
    int1N = 0; cyc(2); int1N = 1; cyc(4);
    check(cpuClkEn == 0, "R7", cpuClkEn, 0);
    cyc(STAB);
    check(cpuClkEn && wakeSrc == 1, "R7", wakeSrc, 1);
    cyc(2);

    // R8 both pins low, first release INT0, priority favours INT1
    writePcon(0, 1); cyc(1);
    int0N = 0; int1N = 0; cyc(3); int0N = 1; cyc(STAB + 2);
    check(cpuClkEn && wakeSrc == 1, "R8", wakeSrc, 1);
    int1N = 1;
    // R8 equal priority favours INT0
    px1 = 0; cyc(2);
    writePcon(0, 1); cyc(1);
    int0N = 0; int1N = 0; cyc(3); int1N = 1; cyc(STAB + 2);
    check(cpuClkEn && wakeSrc == 0, "R8", wakeSrc, 0);
    int0N = 1; cyc(2);

    // R9 reset during both power-down phases
    writePcon(0, 1); cyc(2);
    rstPin = 1; cyc(1); rstPin = 0;
    check(cpuClkEn && oscEn && !pdBit && !wakeValid, "R9", cpuClkEn, 1);
    writePcon(0, 1); cyc(1);
    int0N = 0; cyc(3);
    rstPin = 1; cyc(1); rstPin = 0; int0N = 1;
    check(cpuClkEn && !pdBit && !wakeValid, "R9", pdBit, 0);
    cyc(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule